// File: doc/BRIEF.md
# Debug Port Control and Status Registers

This block gives an external debug host two 32-bit registers. Through them the host can steer the chip while the core is held, halted or being erased. Writes to the control word drive several requests: a flash mass-erase request, a forced debug-logic shutdown, a core halt request, a system reset request and a hold on the core's reset. The status word reports two things from the flash controller: whether an erase it was asked for has started, and whether flash initialisation has finished. Flash ready is valid even while the debugger keeps the system in reset.

The control word is reset only by the power-on/debug reset. The system reset it can request does not clear it, with one exception. The erase request bit has its own life: it sets when the host writes a one and stays set until the flash controller acknowledges. If erase was not permitted at launch, it stays set until the next system reset. A core-hold bit decides whether the core stays in reset after system reset sequencing ends. A timestamp-freeze bit stops a trace timestamp counter while the core is halted.

Top module: `dbg_port_regs`

## Requirements
- R1: After por_n is released, every control and status bit reads zero, all request outputs are low and ts_count_o is zero.
- R2: In the control word (reg_sel=0), bit 1 is debug-off, bit 2 is halt, bit 3 is system reset request, bit 4 is core hold and bit 8 is timestamp freeze. Each takes the written value and reads back at the same position. Bits 5–7 and 9–31 read zero whatever is written.
- R3: The status word (reg_sel=1) has erase acknowledge at bit 0 and flash_ready_i at bit 1. All other bits read zero, and a write with reg_sel=1 changes no register.
- R4: Writing a one to control bit 0 while it is clear starts an erase. The bit reads one, status bit 0 clears, and if erase_allow_i is high, erase_req_o is high for exactly the one cycle after the write edge.
- R5: Control bit 0 can only be set by a write. Writing zero while an erase is pending leaves it set, and writing one again while pending issues no new erase_req_o.
- R6: While a permitted erase is pending, the clock edge that samples erase_ack_i high sets status bit 0 and clears control bit 0. erase_ack_i has no effect when no permitted erase is pending.
- R7: If erase_allow_i is low at launch, no erase_req_o is issued. Control bit 0 then stays set and status bit 0 stays clear, even if erase_ack_i rises, until sys_in_reset.
- R8: Every clock edge with sys_in_reset high clears control bit 0 and status bit 0 and ignores a launch. The other control bits keep their values.
- R9: dbg_disable_o follows control bit 1 and sys_rst_req_o follows control bit 3. halt_req_o is control bit 2 gated off while control bit 1 is set.
- R10: core_rst_o is high while sys_in_reset is high. After sys_in_reset falls it stays high only if core hold was set at the end of reset. Clearing core hold drops core_rst_o right after the write edge, and setting core hold while the core runs does not reset it.
- R11: ts_count_o increases by one per clock while trace_en_i is high and ts_freeze_o is low. ts_freeze_o is control bit 8 AND core_halted_i. The count holds in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on/debug reset, active low, asynchronous |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | 0 selects control word, 1 selects status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| erase_allow_i | input | 1 | Mass erase permitted by enable and security settings |
| erase_ack_i | input | 1 | Flash controller has started the erase |
| flash_ready_i | input | 1 | Flash initialisation complete |
| sys_in_reset | input | 1 | System is in reset sequencing |
| core_halted_i | input | 1 | Core is in debug halt |
| trace_en_i | input | 1 | Trace enabled; timestamp may count |
| erase_req_o | output | 1 | One-cycle mass erase request to flash |
| dbg_disable_o | output | 1 | Forces debug logic off |
| halt_req_o | output | 1 | Halt (and wake) request to the core |
| sys_rst_req_o | output | 1 | Holds the system in reset while high |
| core_rst_o | output | 1 | Core reset |
| ts_freeze_o | output | 1 | Timestamp counter frozen |
| ts_count_o | output | 48 | Trace timestamp value |

## Verification
Checks in the RTL run on every cycle and cover several behaviours: the request pulse never lasts past one cycle and never leaves without a permitted pending erase, system reset wipes the erase state, a sampled acknowledge retires the request, a blocked erase stays pending, the core stays in reset during sequencing, and the timestamp either steps by one or holds. Other behaviours are shown only by the bench scenarios. These are the exact readback images across all 32 writable control patterns, the write-one-to-set behaviour of bit 0, an acknowledge that is ignored when nothing is pending, and the contrast in core release between setting core hold before reset and setting it after.

// File: rtl/dbgpr_pkg.sv
package dbgpr_pkg;
   localparam int unsigned CB_ERASE  = 0;
   localparam int unsigned CB_DBGOFF = 1;
   localparam int unsigned CB_HALT   = 2;
   localparam int unsigned CB_SYSRST = 3;
   localparam int unsigned CB_CHOLD  = 4;
   localparam int unsigned CB_TSFRZ  = 8;
   localparam int unsigned SB_ACK    = 0;
   localparam int unsigned SB_READY  = 1;
   localparam int unsigned MIN_DW    = CB_TSFRZ + 1;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;

   typedef struct packed {
      logic ts_frz;
      logic core_hold;
      logic sys_rst;
      logic halt;
      logic dbg_off;
   } cfg_t;
endpackage

// File: rtl/dbgpr_ctrl.sv
module dbgpr_ctrl
   import dbgpr_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sys_in_reset,
   input  logic              erase_allow_i,
   input  logic              erase_ack_i,
   output cfg_t              cfg_o,
   output logic              pend_o,
   output logic              ack_o,
   output logic              req_o
);
   cfg_t cfg_q;
   logic pend_q, ok_q, ack_q, req_q;
   logic launch;

   assign launch = wr_ctrl & wdata[CB_ERASE] & ~pend_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cfg_q  <= '0;
         pend_q <= 1'b0;
         ok_q   <= 1'b0;
         ack_q  <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (wr_ctrl) begin
            cfg_q <= '{ts_frz:    wdata[CB_TSFRZ],
                       core_hold: wdata[CB_CHOLD],
                       sys_rst:   wdata[CB_SYSRST],
                       halt:      wdata[CB_HALT],
                       dbg_off:   wdata[CB_DBGOFF]};
         end
         if (sys_in_reset) begin
            pend_q <= 1'b0;
            ok_q   <= 1'b0;
            ack_q  <= 1'b0;
         end else if (launch) begin
            pend_q <= 1'b1;
            ok_q   <= erase_allow_i;
            ack_q  <= 1'b0;
            req_q  <= erase_allow_i;
         end else if (pend_q && ok_q && erase_ack_i) begin
            pend_q <= 1'b0;
            ok_q   <= 1'b0;
            ack_q  <= 1'b1;
         end
      end
   end

   assign cfg_o  = cfg_q;
   assign pend_o = pend_q;
   assign ack_o  = ack_q;
   assign req_o  = req_q;

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
      req_q |=> !req_q); // R4
   AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!por_n)
      req_q |-> (pend_q && ok_q)); // R4
   AST_SYSRST_WIPES: assert property (@(posedge clk) disable iff (!por_n)
      sys_in_reset |=> (!pend_q && !ack_q)); // R8
   AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!por_n)
      (pend_q && ok_q && erase_ack_i && !sys_in_reset) |=> (!pend_q && ack_q)); // R6
   AST_BLOCKED_STAYS: assert property (@(posedge clk) disable iff (!por_n)
      (pend_q && !ok_q && !sys_in_reset) |=> (pend_q && !ack_q)); // R7
endmodule

// File: rtl/dbgpr_core_hold.sv
module dbgpr_core_hold (
   input  logic clk,
   input  logic por_n,
   input  logic sys_in_reset,
   input  logic hold_cfg,
   output logic core_rst_o
);
   logic hold_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)            hold_q <= 1'b0;
      else if (sys_in_reset) hold_q <= hold_cfg;
      else                   hold_q <= hold_q & hold_cfg;
   end

   assign core_rst_o = sys_in_reset | (hold_q & hold_cfg);

   AST_CORE_IN_SYSRST: assert property (@(posedge clk) disable iff (!por_n)
      sys_in_reset |-> core_rst_o); // R10
   AST_CORE_FREE_EXIT: assert property (@(posedge clk) disable iff (!por_n)
      ($fell(sys_in_reset) && !$past(hold_cfg)) |-> !core_rst_o); // R10
endmodule

// File: rtl/dbgpr_tstamp.sv
module dbgpr_tstamp #(
   parameter int unsigned TS_W  = 48,
   parameter bit          TS_EN = 1'b1
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            run,
   output logic [TS_W-1:0] count_o
);
   localparam logic [TS_W-1:0] ONE = TS_W'(1);

   generate
      if (TS_EN) begin : g_cnt
         logic [TS_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)   cnt_q <= '0;
            else if (run) cnt_q <= cnt_q + ONE;
         end
         assign count_o = cnt_q;

         AST_TS_STEP: assert property (@(posedge clk) disable iff (!por_n)
            run |=> (cnt_q == $past(cnt_q) + ONE)); // R11
         AST_TS_HOLD: assert property (@(posedge clk) disable iff (!por_n)
            !run |=> $stable(cnt_q)); // R11
      end else begin : g_none
         assign count_o = '0;
      end
   endgenerate
endmodule

// File: rtl/dbg_port_regs.sv
module dbg_port_regs
   import dbgpr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned TS_W   = 48,
   parameter bit          TS_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              erase_allow_i,
   input  logic              erase_ack_i,
   input  logic              flash_ready_i,
   input  logic              sys_in_reset,
   input  logic              core_halted_i,
   input  logic              trace_en_i,
   output logic              erase_req_o,
   output logic              dbg_disable_o,
   output logic              halt_req_o,
   output logic              sys_rst_req_o,
   output logic              core_rst_o,
   output logic              ts_freeze_o,
   output logic [TS_W-1:0]   ts_count_o
);
   generate
      if (DATA_W < MIN_DW) begin : g_bad_dw
         $error("dbg_port_regs: DATA_W too small for control fields");
      end
      if (TS_W < 1 || TS_W > 64) begin : g_bad_ts
         $error("dbg_port_regs: TS_W must be 1..64");
      end
   endgenerate

   cfg_t cfg;
   logic pend, ack, wr_ctrl;
   logic [DATA_W-1:0] ctrl_img, stat_img;

   assign wr_ctrl = reg_wr & (reg_sel_e'(reg_sel) == SEL_CTRL);

   dbgpr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .por_n(por_n), .wr_ctrl(wr_ctrl), .wdata(reg_wdata),
      .sys_in_reset(sys_in_reset), .erase_allow_i(erase_allow_i),
      .erase_ack_i(erase_ack_i), .cfg_o(cfg), .pend_o(pend),
      .ack_o(ack), .req_o(erase_req_o)
   );

   dbgpr_core_hold u_hold (
      .clk(clk), .por_n(por_n), .sys_in_reset(sys_in_reset),
      .hold_cfg(cfg.core_hold), .core_rst_o(core_rst_o)
   );

   assign ts_freeze_o = cfg.ts_frz & core_halted_i;

   dbgpr_tstamp #(.TS_W(TS_W), .TS_EN(TS_EN)) u_ts (
      .clk(clk), .por_n(por_n), .run(trace_en_i & ~ts_freeze_o),
      .count_o(ts_count_o)
   );

   assign dbg_disable_o = cfg.dbg_off;
   assign sys_rst_req_o = cfg.sys_rst;
   assign halt_req_o    = cfg.halt & ~cfg.dbg_off;

   always_comb begin
      ctrl_img            = '0;
      ctrl_img[CB_ERASE]  = pend;
      ctrl_img[CB_DBGOFF] = cfg.dbg_off;
      ctrl_img[CB_HALT]   = cfg.halt;
      ctrl_img[CB_SYSRST] = cfg.sys_rst;
      ctrl_img[CB_CHOLD]  = cfg.core_hold;
      ctrl_img[CB_TSFRZ]  = cfg.ts_frz;
      stat_img            = '0;
      stat_img[SB_ACK]    = ack;
      stat_img[SB_READY]  = flash_ready_i;
   end

   assign reg_rdata = (reg_sel_e'(reg_sel) == SEL_STAT) ? stat_img : ctrl_img;

   AST_STAT_WR_INERT: assert property (@(posedge clk) disable iff (!por_n)
      (reg_wr && reg_sel && !sys_in_reset && !(pend && erase_ack_i)) |=>
      ($stable(cfg) && $stable(pend))); // R3
endmodule

// File: tb/dbg_port_regs_tb.sv
module dbg_port_regs_tb;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        erase_allow_i = 1'b1;
   logic        erase_ack_i = 1'b0;
   logic        flash_ready_i = 1'b0;
   logic        sys_in_reset = 1'b0;
   logic        core_halted_i = 1'b0;
   logic        trace_en_i = 1'b0;
   logic        erase_req_o, dbg_disable_o, halt_req_o, sys_rst_req_o;
   logic        core_rst_o, ts_freeze_o;
   logic [47:0] ts_count_o;

   int total = 0;
   int fails = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   dbg_port_regs u_dut (
      .clk(clk), .por_n(por_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .erase_allow_i(erase_allow_i), .erase_ack_i(erase_ack_i),
      .flash_ready_i(flash_ready_i), .sys_in_reset(sys_in_reset),
      .core_halted_i(core_halted_i), .trace_en_i(trace_en_i),
      .erase_req_o(erase_req_o), .dbg_disable_o(dbg_disable_o),
      .halt_req_o(halt_req_o), .sys_rst_req_o(sys_rst_req_o),
      .core_rst_o(core_rst_o), .ts_freeze_o(ts_freeze_o),
      .ts_count_o(ts_count_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [31:0] d);
      reg_sel = sel;
      #1;
      d = reg_rdata;
   endtask

   task automatic sys_pulse(input int n);
      @(negedge clk);
      sys_in_reset = 1'b1;
      repeat (n) @(negedge clk);
      sys_in_reset = 1'b0;
   endtask

   task automatic ack_cycle();
      @(negedge clk);
      erase_ack_i = 1'b1;
      @(negedge clk);
      erase_ack_i = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      logic [47:0] c0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(1'b0, r); chk("R1", "ctrl after reset", r, 0);
      rd(1'b1, r); chk("R1", "status after reset", r, 0);
      chk("R1", "outputs after reset",
          {erase_req_o, dbg_disable_o, halt_req_o, sys_rst_req_o, core_rst_o, ts_freeze_o}, 0);
      chk("R1", "timestamp after reset", ts_count_o, 0);

      // R2/R9 exhaustive sweep of writable config bits, reserved bits all ones
      for (int p = 0; p < 32; p++) begin
         logic [31:0] d, e;
         e = '0;
         e[1] = p[0]; e[2] = p[1]; e[3] = p[2]; e[4] = p[3]; e[8] = p[4];
         d = e | 32'hFFFF_FEE0;
         wr(1'b0, d);
         rd(1'b0, r); chk("R2", "ctrl readback", r, e);
         chk("R9", "dbg_disable_o", dbg_disable_o, e[1]);
         chk("R9", "sys_rst_req_o", sys_rst_req_o, e[3]);
         chk("R9", "halt_req_o", halt_req_o, e[2] & ~e[1]);
         wr(1'b1, 32'hFFFF_FFFF);
         rd(1'b0, r); chk("R3", "ctrl after status write", r, e);
      end
      wr(1'b0, 0);

      // R3 status layout
      flash_ready_i = 1'b1;
      rd(1'b1, r); chk("R3", "flash ready bit", r, 32'h2);
      flash_ready_i = 1'b0;
      rd(1'b1, r); chk("R3", "flash ready low", r, 0);

      // R4 launch permitted erase
      erase_allow_i = 1'b1;
      wr(1'b0, 32'h1);
      chk("R4", "erase_req_o cycle after write", erase_req_o, 1);
      rd(1'b0, r); chk("R4", "ctrl bit0 pending", r, 32'h1);
      rd(1'b1, r); chk("R4", "ack clear at launch", r, 0);
      @(negedge clk);
      chk("R4", "erase_req_o one cycle only", erase_req_o, 0);
      // R6 acknowledge
      ack_cycle();
      rd(1'b1, r); chk("R6", "ack set", r, 32'h1);
      rd(1'b0, r); chk("R6", "ctrl bit0 cleared", r, 0);

      // R5 write-one-to-set
      wr(1'b0, 32'h1);
      rd(1'b1, r); chk("R4", "ack cleared by relaunch", r, 0);
      chk("R4", "second launch pulses", erase_req_o, 1);
      wr(1'b0, 32'h0);
      rd(1'b0, r); chk("R5", "write zero keeps bit0", r, 32'h1);
      wr(1'b0, 32'h1);
      chk("R5", "no re-request while pending", erase_req_o, 0);
      ack_cycle();
      rd(1'b0, r); chk("R6", "retired again", r, 0);

      // R8 system reset clears ack; R6 ack ignored with nothing pending
      sys_pulse(2);
      rd(1'b1, r); chk("R8", "ack cleared by sys reset", r, 0);
      ack_cycle();
      rd(1'b1, r); chk("R6", "stray ack ignored", r, 0);
      rd(1'b0, r); chk("R6", "stray ack no ctrl change", r, 0);

      // R7 blocked erase
      erase_allow_i = 1'b0;
      wr(1'b0, 32'h10B);
      chk("R7", "no request when blocked", erase_req_o, 0);
      erase_allow_i = 1'b1;
      ack_cycle();
      rd(1'b1, r); chk("R7", "blocked never acked", r, 0);
      repeat (20) @(negedge clk);
      rd(1'b0, r); chk("R7", "blocked bit0 held", r, 32'h10B);
      sys_pulse(1);
      rd(1'b0, r); chk("R8", "sys reset keeps other bits", r, 32'h10A);
      chk("R8", "no request around sys reset", erase_req_o, 0);

      // R10 core hold
      wr(1'b0, 32'h10);
      @(negedge clk);
      sys_in_reset = 1'b1;
      @(negedge clk);
      chk("R10", "core in reset during sys reset", core_rst_o, 1);
      @(negedge clk);
      sys_in_reset = 1'b0;
      #1; chk("R10", "core held after exit", core_rst_o, 1);
      repeat (5) @(negedge clk);
      chk("R10", "core still held", core_rst_o, 1);
      wr(1'b0, 32'h0);
      chk("R10", "clearing hold releases", core_rst_o, 0);
      sys_pulse(2);
      #1; chk("R10", "no hold releases with system", core_rst_o, 0);
      wr(1'b0, 32'h10);
      repeat (3) @(negedge clk);
      chk("R10", "late hold does not reset core", core_rst_o, 0);
      wr(1'b0, 32'h0);

      // R11 timestamp
      trace_en_i = 1'b0;
      @(negedge clk); c0 = ts_count_o;
      repeat (7) @(negedge clk);
      chk("R11", "hold with trace off", ts_count_o, c0);
      trace_en_i = 1'b1;
      c0 = ts_count_o;
      repeat (10) @(negedge clk);
      chk("R11", "count with trace on", ts_count_o, c0 + 48'd10);
      core_halted_i = 1'b1;
      #1; chk("R11", "no freeze when bit8 clear", ts_freeze_o, 0);
      c0 = ts_count_o;
      repeat (10) @(negedge clk);
      chk("R11", "halted counts when bit8 clear", ts_count_o, c0 + 48'd10);
      wr(1'b0, 32'h100);
      chk("R11", "freeze asserted", ts_freeze_o, 1);
      c0 = ts_count_o;
      repeat (9) @(negedge clk);
      chk("R11", "frozen while halted", ts_count_o, c0);
      core_halted_i = 1'b0;
      #1; chk("R11", "freeze drops on resume", ts_freeze_o, 0);
      c0 = ts_count_o;
      repeat (4) @(negedge clk);
      chk("R11", "resumes counting", ts_count_o, c0 + 48'd4);

      finish_run();
   end
endmodule